// File: doc/BRIEF.md
# Buffered Dual-Alignment PWM Channel

This block is one 8-bit pulse-width modulation channel. A free-running counter, advanced by a prescaled clock-enable tick, is compared against a duty value. The output pin changes level at each match. A global mode input chooses between two counting schemes. In left-aligned counting the counter climbs to the period value and then wraps. In center-aligned counting it climbs to the period value and falls back to zero. A polarity input picks which level the output takes at the start of each period.

Period and duty are loaded through a small write port and can be read back through a read port. A duty value written while the channel runs is parked in a shadow register. The comparator only sees it at the next counter rollover, or as soon as the channel is disabled, so a period never mixes two duty values. A wait-mode input, together with a halt-in-wait control, can freeze the counter.

Top module: `pwm_dual_align`

## Requirements
- R1: Left-aligned mode (`center` = 0): the counter visits 0 through the period value P and then returns to 0. With duty D < P, the output is at the active level for exactly D+1 of every P+1 advancing ticks, starting at count 0.
- R2: Center-aligned mode (`center` = 1): the counter climbs from 0 to P and descends back to 0, so a period lasts 2·P advancing ticks. With D < P, the output is active for exactly 2·D of them, which gives a duty fraction of D/P.
- R3: The active level equals the `polarity` input and the inactive level is its inverse. With `polarity` = 0, the high fraction in left-aligned mode is (P−D)/(P+1).
- R4: An active duty value D ≥ P (and D ≠ 0xFF) produces no transition: the output stays at the active level for the whole period.
- R5: An active duty value of 0xFF holds the output at the inactive level at all times.
- R6: A duty write made while `enable` = 1 goes only to the shadow and becomes active at the next rollover. A duty write made while `enable` = 0 becomes active on the following clock.
- R7: `rd_data` returns the most recent value written to the selected register: `rd_sel` = 0 selects the period, `rd_sel` = 1 selects the duty, even when that duty is not yet active. The same encoding applies to `wr_sel`.
- R8: While `enable` = 0, the counter is held at 0 and the output sits at the inactive level. After `enable` rises, the first period starts at count 0.
- R9: The counter advances only on clocks with `tick` = 1. With `halt_wait` = 1 and `wait_i` = 1 it does not advance. With `halt_wait` = 0, `wait_i` has no effect.
- R10: A period write takes effect on the following clock, including while the channel runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled counter advance enable |
| wait_i | input | 1 | Wait-mode indication |
| halt_wait | input | 1 | Freeze the counter while `wait_i` is high |
| center | input | 1 | 0 = left-aligned, 1 = center-aligned counting |
| enable | input | 1 | Channel run enable |
| polarity | input | 1 | Active output level |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 period, 1 duty |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 period, 1 duty |
| rd_data | output | 8 | Read data |
| pwm_o | output | 1 | PWM output level |

## Verification
The hardest case to reach is a duty write that lands while the channel runs mid-period. The old value must govern the rest of that period and the new one the next, and the read port must already show the new value. A write that coincides with a rollover is also hard to hit. Directed sequences restart the counter from a disabled state, write the duty on the first or a later tick of a measured period, and count active cycles in each of the two following periods. Long random runs, with writes on roughly one clock in eight, also land writes on rollover edges and during halted or tick-less clocks, and a cycle-level model checks each one.

// File: rtl/pwm_da_pkg.sv
package pwm_da_pkg;

   typedef enum logic {
      SEL_PERIOD = 1'b0,
      SEL_DUTY   = 1'b1
   } reg_sel_e;

   typedef struct packed {
      logic run;
      logic adv;
      logic center;
   } cnt_ctl_t;

endpackage

// File: rtl/pwm_da_regs.sv
module pwm_da_regs
   import pwm_da_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic         wr_sel,
   input  logic [W-1:0] wr_data,
   input  logic         load,
   output logic [W-1:0] period,
   output logic [W-1:0] duty_sh,
   output logic [W-1:0] duty_act
);

   logic         wr_duty;
   logic         wr_per;
   logic [W-1:0] sh_nxt;

   assign wr_duty = wr_en && (reg_sel_e'(wr_sel) == SEL_DUTY);
   assign wr_per  = wr_en && (reg_sel_e'(wr_sel) == SEL_PERIOD);
   assign sh_nxt  = wr_duty ? wr_data : duty_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period   <= '0;
         duty_sh  <= '0;
         duty_act <= '0;
      end else begin
         if (wr_per) period <= wr_data;
         duty_sh <= sh_nxt;
         if (load) duty_act <= sh_nxt;
      end
   end

endmodule

// File: rtl/pwm_da_count.sv
module pwm_da_count
   import pwm_da_pkg::*;
#(
   parameter int W         = 8,
   parameter bit CENTER_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  cnt_ctl_t     ctl,
   input  logic [W-1:0] period,
   output logic [W-1:0] cnt,
   output logic         up,
   output logic         roll
);

   localparam logic [W-1:0] ONE = W'(1);

   logic center_eff;

   generate
      if (CENTER_EN) begin : g_dual
         assign center_eff = ctl.center;
      end else begin : g_left_only
         logic unused_center;
         assign unused_center = ctl.center;
         assign center_eff    = 1'b0;
      end
   endgenerate

   logic at_top;
   logic at_floor;
   assign at_top   = (cnt >= period);
   assign at_floor = (cnt <= ONE);

   assign roll = ctl.run && ctl.adv &&
                 (center_eff ? (up ? (at_top && (period == '0)) : at_floor)
                             : at_top);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         up  <= 1'b1;
      end else if (!ctl.run) begin
         cnt <= '0;
         up  <= 1'b1;
      end else if (ctl.adv) begin
         if (!center_eff) begin
            up  <= 1'b1;
            cnt <= at_top ? '0 : cnt + ONE;
         end else if (up) begin
            if (at_top) begin
               if (period == '0) begin
                  cnt <= '0;
               end else begin
                  up  <= 1'b0;
                  cnt <= cnt - ONE;
               end
            end else begin
               cnt <= cnt + ONE;
            end
         end else begin
            if (at_floor) begin
               cnt <= '0;
               up  <= 1'b1;
            end else begin
               cnt <= cnt - ONE;
            end
         end
      end
   end

endmodule

// File: rtl/pwm_da_shape.sv
module pwm_da_shape #(
   parameter int W = 8
) (
   input  logic [W-1:0] cnt,
   input  logic         up,
   input  logic         center,
   input  logic         enable,
   input  logic         polarity,
   input  logic [W-1:0] period,
   input  logic [W-1:0] duty,
   output logic         pwm_o
);

   logic pinned;
   logic full;
   logic cmp;
   logic act;

   assign pinned = &duty;
   assign full   = (duty >= period);

   always_comb begin
      if (!center)  cmp = (cnt <= duty);
      else if (up)  cmp = (cnt < duty);
      else          cmp = (cnt <= duty);
   end

   assign act   = pinned ? 1'b0 : (full ? 1'b1 : cmp);
   assign pwm_o = (enable && act) ? polarity : ~polarity;

endmodule

// File: rtl/pwm_dual_align.sv
module pwm_dual_align
   import pwm_da_pkg::*;
#(
   parameter int W         = 8,
   parameter bit CENTER_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         wait_i,
   input  logic         halt_wait,
   input  logic         center,
   input  logic         enable,
   input  logic         polarity,
   input  logic         wr_en,
   input  logic         wr_sel,
   input  logic [W-1:0] wr_data,
   input  logic         rd_sel,
   output logic [W-1:0] rd_data,
   output logic         pwm_o
);

   generate
      if (W < 2) begin : g_bad_width
         $error("pwm_dual_align: W must be at least 2");
      end
   endgenerate

   cnt_ctl_t     ctl;
   logic [W-1:0] period;
   logic [W-1:0] duty_sh;
   logic [W-1:0] duty_act;
   logic [W-1:0] cnt;
   logic         up;
   logic         roll;
   logic         center_eff;

   assign center_eff = CENTER_EN ? center : 1'b0;
   assign ctl.run    = enable;
   assign ctl.adv    = tick && !(halt_wait && wait_i);
   assign ctl.center = center_eff;

   pwm_da_regs #(.W(W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .load     (roll || !enable),
      .period   (period),
      .duty_sh  (duty_sh),
      .duty_act (duty_act)
   );

   pwm_da_count #(.W(W), .CENTER_EN(CENTER_EN)) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl    (ctl),
      .period (period),
      .cnt    (cnt),
      .up     (up),
      .roll   (roll)
   );

   pwm_da_shape #(.W(W)) u_shape (
      .cnt      (cnt),
      .up       (up),
      .center   (center_eff),
      .enable   (enable),
      .polarity (polarity),
      .period   (period),
      .duty     (duty_act),
      .pwm_o    (pwm_o)
   );

   assign rd_data = (reg_sel_e'(rd_sel) == SEL_DUTY) ? duty_sh : period;

endmodule

// File: rtl/pwm_dual_align_chk.sv
module pwm_dual_align_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         enable,
   input logic         polarity,
   input logic         tick,
   input logic         wait_i,
   input logic         halt_wait,
   input logic         wr_en,
   input logic         wr_sel,
   input logic [W-1:0] wr_data,
   input logic         pwm_o,
   input logic [W-1:0] cnt,
   input logic         roll,
   input logic [W-1:0] period,
   input logic [W-1:0] duty_sh,
   input logic [W-1:0] duty_act
);

   assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (pwm_o == ~polarity));

   assert_idle_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (cnt == '0));

   assert_pinned_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && (&duty_act)) |-> (pwm_o == ~polarity));

   assert_no_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !(&duty_act) && (duty_act >= period)) |-> (pwm_o == polarity));

   assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && (!tick || (halt_wait && wait_i))) ##1 enable |-> $stable(cnt));

   assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !roll) ##1 enable |-> $stable(duty_act));

   assert_last_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel) |=> (duty_sh == $past(wr_data)));

endmodule

bind pwm_dual_align pwm_dual_align_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .enable    (enable),
   .polarity  (polarity),
   .tick      (tick),
   .wait_i    (wait_i),
   .halt_wait (halt_wait),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_data   (wr_data),
   .pwm_o     (pwm_o),
   .cnt       (cnt),
   .roll      (roll),
   .period    (period),
   .duty_sh   (duty_sh),
   .duty_act  (duty_act)
);

// File: tb/sim_pwm_dual_align.sv
`timescale 1ns/1ps
module sim_pwm_dual_align;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, wait_i = 1'b0, halt_wait = 1'b0, center = 1'b0;
   logic       enable = 1'b0, polarity = 1'b1;
   logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       pwm_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic seen;

   // reference state
   int m_cnt, m_per, m_sh, m_act;
   bit m_up;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_dual_align u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wait_i(wait_i),
      .halt_wait(halt_wait), .center(center), .enable(enable),
      .polarity(polarity), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .pwm_o(pwm_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit model_active();
      if (m_act == 255) return 1'b0;
      if (m_act >= m_per) return 1'b1;
      if (!center) return m_cnt <= m_act;
      if (m_up) return m_cnt < m_act;
      return m_cnt <= m_act;
   endfunction

   function automatic string model_tag();
      if (!enable) return "R8";
      if (m_act == 255) return "R5";
      if (m_act >= m_per) return "R4";
      if (!polarity) return "R3";
      return center ? "R2" : "R1";
   endfunction

   task automatic model_update();
      bit adv, roll;
      int sh_n;
      adv = tick && !(halt_wait && wait_i);
      if (!center) roll = adv && (m_cnt >= m_per);
      else if (m_up) roll = adv && (m_cnt >= m_per) && (m_per == 0);
      else roll = adv && (m_cnt <= 1);
      roll = roll && enable;
      sh_n = (wr_en && wr_sel) ? int'(wr_data) : m_sh;
      if (!enable) begin
         m_cnt = 0; m_up = 1'b1;
      end else if (adv) begin
         if (!center) begin
            m_up = 1'b1;
            m_cnt = (m_cnt >= m_per) ? 0 : m_cnt + 1;
         end else if (m_up) begin
            if (m_cnt >= m_per) begin
               if (m_per == 0) m_cnt = 0;
               else begin m_up = 1'b0; m_cnt = m_cnt - 1; end
            end else m_cnt = m_cnt + 1;
         end else begin
            if (m_cnt <= 1) begin m_cnt = 0; m_up = 1'b1; end
            else m_cnt = m_cnt - 1;
         end
      end
      if (roll || !enable) m_act = sh_n;
      m_sh = sh_n;
      if (wr_en && !wr_sel) m_per = int'(wr_data);
   endtask

   task automatic step();
      logic exp_o;
      int   exp_rd;
      #1;
      exp_o = enable ? (model_active() ? polarity : ~polarity) : ~polarity;
      check(pwm_o === exp_o, model_tag(), int'(pwm_o), int'(exp_o));
      exp_rd = rd_sel ? m_sh : m_per;
      check(rd_data === 8'(exp_rd), "R7", int'(rd_data), exp_rd);
      seen = pwm_o;
      @(posedge clk);
      model_update();
      @(negedge clk);
   endtask

   task automatic wr(input bit sel, input int val);
      wr_en = 1'b1; wr_sel = sel; wr_data = 8'(val);
      step();
      wr_en = 1'b0;
   endtask

   // program with the channel stopped, then restart from count 0
   task automatic setup(input bit ctr, input bit pol, input int p, input int d);
      enable = 1'b0; tick = 1'b1; halt_wait = 1'b0; wait_i = 1'b0;
      step();
      center = ctr; polarity = pol;
      wr(1'b0, p);
      wr(1'b1, d);
      enable = 1'b1;
   endtask

   task automatic count_active(input int n, output int a);
      a = 0;
      for (int i = 0; i < n; i++) begin
         step();
         if (seen == polarity) a++;
      end
   endtask

   initial begin
      int a, b;
      void'($urandom(32'h1A2B3C4D));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_cnt = 0; m_up = 1'b1; m_per = 0; m_sh = 0; m_act = 0;

      // reset state
      #1;
      check(pwm_o === 1'b0, "R8 reset level", int'(pwm_o), 0);
      check(rd_data === 8'h00, "R7 reset period", int'(rd_data), 0);
      step();

      // R1 left, pol 1
      setup(1'b0, 1'b1, 9, 3);
      count_active(10, a); check(a == 4, "R1 left fraction", a, 4);
      // R3 polarity 0: high count is the inactive count
      setup(1'b0, 1'b0, 9, 3);
      count_active(10, a); check(10 - a == 6, "R3 high with pol 0", 10 - a, 6);
      // R2 center
      setup(1'b1, 1'b1, 8, 3);
      count_active(16, a); check(a == 6, "R2 center fraction", a, 6);
      // R4 duty equals period, and above period in center
      setup(1'b0, 1'b1, 9, 9);
      count_active(10, a); check(a == 10, "R4 left duty=period", a, 10);
      setup(1'b1, 1'b1, 9, 200);
      count_active(18, a); check(a == 18, "R4 center duty>period", a, 18);
      // R5 pinned
      setup(1'b0, 1'b1, 9, 255);
      count_active(10, a); check(a == 0, "R5 duty 0xFF", a, 0);
      // R6 write while running: old value governs this period
      setup(1'b0, 1'b1, 9, 2);
      wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'd6;
      step(); a = (seen == polarity) ? 1 : 0;
      wr_en = 1'b0; rd_sel = 1'b1;
      #1 check(rd_data === 8'd6, "R7 readback of pending duty", int'(rd_data), 6);
      count_active(9, b); a += b;
      check(a == 3, "R6 old duty holds", a, 3);
      count_active(10, a); check(a == 7, "R6 new duty at rollover", a, 7);
      rd_sel = 1'b0;
      // R6 write while disabled applies at once
      setup(1'b0, 1'b1, 9, 4);
      count_active(10, a); check(a == 5, "R6 disabled write immediate", a, 5);
      // R8 restart from 0 after disable mid-period
      count_active(3, a);
      enable = 1'b0; step();
      check(seen == ~polarity, "R8 idle level", int'(seen), int'(~polarity));
      enable = 1'b1;
      count_active(10, a); check(a == 5, "R8 restart at count 0", a, 5);
      // R9 half-rate tick: period doubles
      setup(1'b0, 1'b1, 4, 1);
      a = 0;
      for (int i = 0; i < 10; i++) begin
         tick = (i % 2 == 0); step(); if (seen == polarity) a++;
      end
      check(a == 4, "R9 tick gating", a, 4);
      // R9 halt in wait freezes the counter
      tick = 1'b1; halt_wait = 1'b1; wait_i = 1'b1;
      count_active(12, a); check(a == 12, "R9 frozen at count 0", a, 12);
      halt_wait = 1'b0;
      count_active(5, a); check(a == 2, "R9 wait ignored when not halting", a, 2);
      wait_i = 1'b0;
      // R10 period write while running
      setup(1'b0, 1'b1, 9, 2);
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'd4;
      step(); a = (seen == polarity) ? 1 : 0;
      wr_en = 1'b0;
      count_active(9, b); a += b;
      check(a == 6, "R10 new period immediate", a, 6);

      // constrained random phase, cross-checked each clock
      for (int i = 0; i < 6000; i++) begin
         tick      = ($urandom_range(0, 3) != 0);
         wait_i    = ($urandom_range(0, 5) == 0);
         halt_wait = ($urandom_range(0, 1) == 1);
         polarity  = ($urandom_range(0, 1) == 1);
         rd_sel    = ($urandom_range(0, 1) == 1);
         if ($urandom_range(0, 60) == 0) enable = ~enable;
         if (!enable && $urandom_range(0, 3) == 0) center = ~center;
         wr_en = ($urandom_range(0, 7) == 0);
         wr_sel = ($urandom_range(0, 2) != 0);
         case ($urandom_range(0, 5))
            0:       wr_data = 8'hFF;
            1:       wr_data = 8'($urandom_range(0, 255));
            default: wr_data = 8'($urandom_range(0, 12));
         endcase
         step();
      end
      wr_en = 1'b0;

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired (R1) actual=0 expected=1");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule